// File: doc/BRIEF.md
# Status-Code Two-Wire Bus Master

This block is a byte-oriented master for a two-wire serial bus (I2C style). Software works it through three byte-wide registers: control, status and data. It advances the bus one event at a time. Each event ends with the interrupt flag raised and a fixed hexadecimal code in the status register. Software reads that code to choose its next step. While the flag stays set, the block holds the bus with the clock line low. It continues only when software clears the flag. The write that clears the flag also says what comes next: one more byte, a repeated START, or a STOP.

The master drives SCL and SDA open-drain. An output enable of 1 pulls a line low. Both lines are read back through two-stage synchronizers. The block sends the address byte and any write data, and it receives read data. After a received byte it returns ACK or NACK as software selects. A repeated START switches the bus direction. If SDA reads low while the master is releasing it during an address or transmit bit, the master gives up the bus and reports it. A 3-bit rate field picks the bit rate. Each SCL period is four equal quarters, and one quarter lasts 4·2^rate system clocks.

Top module: `i2c_status_master`

## Requirements
- R1: After reset the control register reads 00h, the status register reads F8h, the data register reads 00h, `irq` is 0, and both output enables are 0.
- R2: Register offsets are 0 for control, 1 for status (read-only) and 2 for data. The control register has these bits: 7 enable, 6 START request, 5 STOP request, 4 interrupt flag, 3 acknowledge enable, [2:0] rate. A write of 0 to bit 4 clears the flag. A write of 1 to bit 4 leaves the flag as it is.
- R3: START happens only when enable=1, START request=1 and the flag is 0. The master then waits until both lines read high, and then pulls SDA low while SCL is high. When this is done it sets the flag, reports status 08h and clears the START request bit.
- R4: While the flag is set after a START or a byte, SCL stays low and has no edges. The master moves on only after software clears the flag.
- R5: Bytes are sent MSB first. SDA changes only while SCL is low. On the ninth clock the master releases SDA to read the acknowledge (low = ACK).
- R6: After the address byte the status is as follows. With LSB 0 (write): 18h for ACK, 20h for NACK. With LSB 1 (read): 40h for ACK, 48h for NACK.
- R7: After a transmitted data byte the status is 28h for ACK and 30h for NACK.
- R8: If the flag is cleared with START request=1 (and STOP request=0), the master produces a repeated START and reports status 10h. A following address with LSB 1 puts the master into receive mode.
- R9: In receive mode the master releases SDA for eight bits and stores the byte in the data register. It then drives ACK (low) if acknowledge enable=1, and NACK (high) if it is 0. The status is 50h after ACK and 58h after NACK.
- R10: If SDA reads low while the master releases it during an address or transmit bit, the master releases both lines, sets the flag and reports status 38h.
- R11: If the flag is cleared with STOP request=1, the master produces a STOP (SDA rises while SCL is high). Hardware then clears the STOP request bit. The flag stays 0 and the status reads F8h.
- R12: During a byte, each SCL high time and each SCL low time between bits lasts 2·4·2^rate system clocks.
- R13: The enable bit and the rate bits change only when software writes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | SCL line as read back from the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | SDA line as read back from the bus |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Arbitration loss is the hardest case to reach from the ports. It needs SDA pulled low from outside at the exact moment the master releases it during a transmit bit. The bench loads an address whose MSB is 1. While the master is frozen after START it pulls SDA low, then clears the flag, so the loss occurs on the very first bit. The bench also holds SDA low in idle to show that START waits for a free bus. A bench slave model serves a read with a master ACK followed by a read with a master NACK. This checks the ACK/NACK choice and when the slave must release the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int RATE_W       = 3;
  localparam int BASE_QUARTER = 4;
  localparam int QCNT_W       = $clog2(BASE_QUARTER << ((1 << RATE_W) - 1)) + 1;
  localparam int BITS_PER_XFER = 9;
  localparam int STEP_W       = $clog2(BITS_PER_XFER * 4);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BITS_PER_XFER * 4 - 1);

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;

  localparam logic [7:0] ST_CODE_START   = 8'h08;
  localparam logic [7:0] ST_CODE_RESTART = 8'h10;
  localparam logic [7:0] ST_CODE_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_CODE_AW_NACK = 8'h20;
  localparam logic [7:0] ST_CODE_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_CODE_TX_NACK = 8'h30;
  localparam logic [7:0] ST_CODE_LOST    = 8'h38;
  localparam logic [7:0] ST_CODE_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_CODE_AR_NACK = 8'h48;
  localparam logic [7:0] ST_CODE_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_CODE_RX_NACK = 8'h58;
  localparam logic [7:0] ST_CODE_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_BYTE, SQ_HOLD, SQ_STOP
  } sq_state_t;

  // System clocks in one quarter of an SCL period.
  function automatic logic [QCNT_W-1:0] quarter_cycles(input logic [RATE_W-1:0] r);
    return QCNT_W'(BASE_QUARTER) << r;
  endfunction

  // Status code reported after the ninth clock of a byte.
  function automatic logic [7:0] byte_code(input logic was_addr, input logic rd_dir,
                                           input logic acked);
    if (was_addr) begin
      if (rd_dir) return acked ? ST_CODE_AR_ACK : ST_CODE_AR_NACK;
      return acked ? ST_CODE_AW_ACK : ST_CODE_AW_NACK;
    end
    if (rd_dir) return acked ? ST_CODE_RX_ACK : ST_CODE_RX_NACK;
    return acked ? ST_CODE_TX_ACK : ST_CODE_TX_NACK;
  endfunction
endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [QCNT_W-1:0] cnt;
  logic [QCNT_W-1:0] reload;

  assign reload = quarter_cycles(rate) - QCNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == '0) cnt <= reload;
    else                        cnt <= cnt - QCNT_W'(1);
  end

  assign tick = run && (cnt == '0);

  // R12: a quarter is never shorter than two clocks
  assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_sequencer.sv
module i2cm_sequencer
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ena,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       flag,
  input  logic       ack_en,
  input  logic       tick,
  input  logic [7:0] tx_byte,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       run,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       set_flag,
  output logic [7:0] code,
  output logic       clr_start,
  output logic       clr_stop,
  output logic       rx_load,
  output logic [7:0] rx_byte
);
  sq_state_t         state;
  logic [STEP_W-1:0] step;
  logic              restart, addr_phase, rx_mode, hold_low, samp;
  logic [7:0]        sh;

  logic [3:0] bit_idx;
  logic       last_bit, rx_data, out_bit;
  logic       start_done, byte_done, stop_done, sample_now, shift_now, lost;

  assign bit_idx  = 4'(step >> 2);
  assign last_bit = (bit_idx == 4'(BITS_PER_XFER - 1));
  assign rx_data  = rx_mode && !addr_phase;
  assign out_bit  = last_bit ? (rx_data ? !ack_en : 1'b1) : (rx_data ? 1'b1 : sh[7]);

  assign start_done = tick && (state == SQ_START) && (step[1:0] == 2'd3);
  assign stop_done  = tick && (state == SQ_STOP)  && (step[1:0] == 2'd3);
  assign byte_done  = tick && (state == SQ_BYTE)  && (step == LAST_STEP);
  assign sample_now = tick && (state == SQ_BYTE)  && (step[1:0] == 2'd2);
  assign shift_now  = tick && (state == SQ_BYTE)  && (step[1:0] == 2'd3) && !last_bit;
  assign lost       = sample_now && !last_bit && !rx_data && sh[7] && !sda_s;

  assign run = (state == SQ_START) || (state == SQ_BYTE) || (state == SQ_STOP);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (state)
      SQ_HOLD:  begin scl_oe = 1'b1; sda_oe = hold_low; end
      SQ_START: begin scl_oe = (step[1:0] == 2'd0) || (step[1:0] == 2'd3);
                      sda_oe = step[1]; end
      SQ_BYTE:  begin scl_oe = !step[1]; sda_oe = !out_bit; end
      SQ_STOP:  begin scl_oe = (step[1:0] == 2'd0); sda_oe = !step[1]; end
      default:  ;
    endcase
  end

  assign set_flag  = start_done || byte_done || lost;
  assign code      = start_done ? (restart ? ST_CODE_RESTART : ST_CODE_START)
                   : lost       ? ST_CODE_LOST
                   : byte_code(addr_phase, rx_mode, !samp);
  assign clr_start = start_done;
  assign clr_stop  = stop_done;
  assign rx_load   = byte_done && rx_data;
  assign rx_byte   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE; step <= '0; restart <= 1'b0; addr_phase <= 1'b0;
      rx_mode <= 1'b0; hold_low <= 1'b0; samp <= 1'b1; sh <= '0;
    end else if (!ena) begin
      state <= SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: if (start_req && !flag && scl_s && sda_s) begin
          state <= SQ_START; step <= STEP_W'(1); restart <= 1'b0;
        end
        SQ_HOLD: if (!flag) begin
          step <= '0;
          if (stop_req)       state <= SQ_STOP;
          else if (start_req) begin state <= SQ_START; restart <= 1'b1; end
          else begin
            state <= SQ_BYTE;
            sh    <= tx_byte;
            if (addr_phase) rx_mode <= tx_byte[0];
          end
        end
        SQ_START: if (tick) begin
          if (step[1:0] == 2'd3) begin
            state <= SQ_HOLD; hold_low <= 1'b1; addr_phase <= 1'b1;
          end else step <= step + STEP_W'(1);
        end
        SQ_BYTE: if (lost) begin
          state <= SQ_IDLE;
        end else if (tick) begin
          if (sample_now) samp <= sda_s;
          if (shift_now)  sh   <= {sh[6:0], samp};
          if (step == LAST_STEP) begin
            state <= SQ_HOLD; hold_low <= 1'b0; addr_phase <= 1'b0;
          end else step <= step + STEP_W'(1);
        end
        SQ_STOP: if (tick) begin
          if (step[1:0] == 2'd3) state <= SQ_IDLE;
          else step <= step + STEP_W'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R5: within a byte, SDA is steady across any cycle where SCL stays released
  assert_sda_steady_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BYTE && $past(state == SQ_BYTE) && !scl_oe && !$past(scl_oe))
      |-> (sda_oe == $past(sda_oe)));
  // R4: with the flag pending and the bus still owned, SCL is pulled low
  assert_clock_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ena && state != SQ_IDLE) |-> scl_oe);
  // R3: bus events never coincide
  assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_done, byte_done, lost, stop_done}));
  // R10: after a loss both lines are released on the next cycle
  assert_release_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  logic              c_ena, c_start, c_stop, c_flag, c_ack;
  logic [RATE_W-1:0] c_rate;
  logic [7:0]        data_q, code_q;
  logic [1:0]        scl_sync, sda_sync;

  logic       run, tick, set_flag, clr_start, clr_stop, rx_load;
  logic [7:0] code, rx_byte;
  logic       wr_ctrl, wr_data;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_data = reg_wr && (reg_addr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_ena <= 1'b0; c_start <= 1'b0; c_stop <= 1'b0; c_flag <= 1'b0;
      c_ack <= 1'b0; c_rate <= '0; data_q <= '0; code_q <= ST_CODE_NONE;
    end else begin
      if (wr_ctrl) begin
        c_ena  <= reg_wdata[7];
        c_ack  <= reg_wdata[3];
        c_rate <= reg_wdata[RATE_W-1:0];
      end
      if (clr_start)    c_start <= 1'b0;
      else if (wr_ctrl) c_start <= reg_wdata[6];
      if (clr_stop)     c_stop <= 1'b0;
      else if (wr_ctrl) c_stop <= reg_wdata[5];
      if (set_flag)     c_flag <= 1'b1;
      else if (wr_ctrl) c_flag <= c_flag & reg_wdata[4];
      if (set_flag)     code_q <= code;
      if (wr_data)      data_q <= reg_wdata;
      else if (rx_load) data_q <= rx_byte;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = {c_ena, c_start, c_stop, c_flag, c_ack, c_rate};
      OFS_STAT: reg_rdata = c_flag ? code_q : ST_CODE_NONE;
      OFS_DATA: reg_rdata = data_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = c_flag;

  i2cm_quarter_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(c_rate), .tick(tick)
  );

  i2cm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .ena(c_ena), .start_req(c_start), .stop_req(c_stop),
    .flag(c_flag), .ack_en(c_ack), .tick(tick), .tx_byte(data_q),
    .scl_s(scl_sync[1]), .sda_s(sda_sync[1]), .run(run), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .set_flag(set_flag), .code(code), .clr_start(clr_start),
    .clr_stop(clr_stop), .rx_load(rx_load), .rx_byte(rx_byte)
  );

  // R13: enable and rate move only on a control write
  assert_cfg_untouched_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(c_ena) && $stable(c_rate)));
  // R6: a pending interrupt always carries a real event code
  assert_code_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_flag |-> (code_q != ST_CODE_NONE));
  // R11: finishing a STOP never raises the flag
  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stop |=> !c_flag);
endmodule

// File: tb/sim_i2c_status_master.sv
module sim_i2c_status_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  wire        scl_line, sda_line;

  bit slave_low = 1'b0, force_low = 1'b0;
  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slave_low || force_low);

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  i2c_status_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  // ---------------- slave model ----------------
  int         s_cnt = 0, s_idx = 0;
  bit         s_addr = 1'b0, s_rd = 1'b0, s_stop = 1'b0;
  bit         addr_ack = 1'b1, data_ack = 1'b1, m_bit9 = 1'b1;
  logic [7:0] s_sh = 8'h00, last_addr = 8'h00, last_rx = 8'h00;
  logic [7:0] s_tx [0:3];

  always @(negedge sda_line) if (scl_line) begin
    s_cnt = 0; s_addr = 1'b1; s_rd = 1'b0; s_idx = 0;
  end
  always @(posedge sda_line) if (scl_line) s_stop = 1'b1;
  always @(posedge scl_line) begin
    if (s_cnt < 8) s_sh = {s_sh[6:0], sda_line};
    else m_bit9 = sda_line;
    s_cnt++;
  end
  always @(negedge scl_line) begin
    if (s_cnt == 8) begin
      if (s_addr) begin
        last_addr = s_sh; s_rd = s_sh[0] && addr_ack; slave_low = addr_ack;
      end else if (!s_rd) begin
        last_rx = s_sh; slave_low = data_ack;
      end else slave_low = 1'b0;
    end else if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_addr) begin
        s_addr = 1'b0;
        slave_low = s_rd ? !s_tx[s_idx][7] : 1'b0;
      end else if (s_rd && !m_bit9) begin
        s_idx++; slave_low = !s_tx[s_idx][7];
      end else begin
        s_rd = 1'b0; slave_low = 1'b0;
      end
    end else if (s_cnt >= 1 && s_cnt <= 7 && s_rd && !s_addr) begin
      slave_low = !s_tx[s_idx][7 - s_cnt];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(req, "interrupt raised", int'(irq), 1);
  endtask

  task automatic wait_stop(input string req);
    logic [7:0] v;
    int n = 0;
    rd(2'd0, v);
    while (v[5] && n < 20000) begin @(negedge clk); n++; rd(2'd0, v); end
    repeat (4) @(negedge clk);
    chk(req, "stop bit cleared", int'(v[5]), 0);
  endtask

  task automatic expect_status(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(2'd1, v);
    chk(req, "status code", int'(v), int'(exp));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1", "control after reset", int'(v), 8'h00);
    rd(2'd1, v); chk("R1", "status after reset", int'(v), 8'hF8);
    rd(2'd2, v); chk("R1", "data after reset", int'(v), 8'h00);
    chk("R1", "irq/oe after reset", int'({irq, scl_oe, sda_oe}), 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd0, 8'h9D);
    rd(2'd0, v); chk("R2", "control readback, flag write ignored", int'(v), 8'h8D);
    wr(2'd2, 8'h6E);
    rd(2'd2, v); chk("R2", "data readback", int'(v), 8'h6E);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R2", "status is read-only", int'(v), 8'hF8);
    wr(2'd0, 8'h80);
  endtask

  task automatic t_write_xfer;
    logic [7:0] v;
    int edges = 0;
    bit prev;
    addr_ack = 1'b1; data_ack = 1'b1;
    wr(2'd0, 8'hC0);
    wait_irq("R3");
    expect_status("R3", 8'h08);
    rd(2'd0, v); chk("R3", "start request auto-cleared", int'(v[6]), 0);
    prev = scl_line;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (scl_line != prev) edges++; prev = scl_line;
    end
    chk("R4", "SCL edges while flag set", edges, 0);
    chk("R4", "SCL level while flag set", int'(scl_line), 0);
    wr(2'd2, 8'hA4); wr(2'd0, 8'h80);
    wait_irq("R6");
    expect_status("R6", 8'h18);
    chk("R5", "address seen by slave", int'(last_addr), 8'hA4);
    wr(2'd2, 8'h3C); wr(2'd0, 8'h80);
    wait_irq("R7");
    expect_status("R7", 8'h28);
    chk("R5", "data byte seen by slave", int'(last_rx), 8'h3C);
    data_ack = 1'b0;
    wr(2'd2, 8'h99); wr(2'd0, 8'h80);
    wait_irq("R7");
    expect_status("R7", 8'h30);
    s_stop = 1'b0;
    wr(2'd0, 8'hA0);
    wait_stop("R11");
    expect_status("R11", 8'hF8);
    chk("R11", "no interrupt after stop", int'(irq), 0);
    chk("R11", "stop condition on bus", int'(s_stop), 1);
    chk("R11", "lines released", int'({scl_line, sda_line}), 3);
  endtask

  task automatic t_read_xfer;
    logic [7:0] v;
    addr_ack = 1'b0; data_ack = 1'b1;
    s_tx[0] = 8'h5A; s_tx[1] = 8'hC3; s_tx[2] = 8'hFF; s_tx[3] = 8'hFF;
    wr(2'd0, 8'hC0);
    wait_irq("R3");
    wr(2'd2, 8'h10); wr(2'd0, 8'h80);
    wait_irq("R6");
    expect_status("R6", 8'h20);
    addr_ack = 1'b1;
    wr(2'd0, 8'hC0);
    wait_irq("R8");
    expect_status("R8", 8'h10);
    wr(2'd2, 8'h11); wr(2'd0, 8'h88);
    wait_irq("R8");
    expect_status("R8", 8'h40);
    wr(2'd0, 8'h88);
    wait_irq("R9");
    expect_status("R9", 8'h50);
    rd(2'd2, v); chk("R9", "first received byte", int'(v), 8'h5A);
    chk("R9", "master ACK driven low", int'(m_bit9), 0);
    wr(2'd0, 8'h80);
    wait_irq("R9");
    expect_status("R9", 8'h58);
    rd(2'd2, v); chk("R9", "second received byte", int'(v), 8'hC3);
    chk("R9", "master NACK left high", int'(m_bit9), 1);
    addr_ack = 1'b0;
    wr(2'd0, 8'hC0);
    wait_irq("R8");
    wr(2'd2, 8'h21); wr(2'd0, 8'h80);
    wait_irq("R6");
    expect_status("R6", 8'h48);
    wr(2'd0, 8'hA0);
    wait_stop("R11");
    addr_ack = 1'b1;
  endtask

  task automatic t_arbitration;
    wr(2'd0, 8'hC0);
    wait_irq("R10");
    wr(2'd2, 8'h80);
    force_low = 1'b1;
    wr(2'd0, 8'h80);
    wait_irq("R10");
    expect_status("R10", 8'h38);
    chk("R10", "SCL released after loss", int'(scl_line), 1);
    force_low = 1'b0;
    @(negedge clk);
    chk("R10", "SDA released after loss", int'(sda_line), 1);
    wr(2'd0, 8'h80);
    expect_status("R10", 8'hF8);
  endtask

  task automatic t_bus_busy;
    force_low = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'hC0);
    repeat (300) @(negedge clk);
    chk("R3", "no START while bus busy", int'({irq, scl_oe}), 0);
    force_low = 1'b0;
    wait_irq("R3");
    expect_status("R3", 8'h08);
    wr(2'd0, 8'hA0);
    wait_stop("R11");
  endtask

  task automatic t_rate(input logic [2:0] r);
    logic [7:0] v;
    int hi = 0, lo = 0, n = 0;
    int exp = 2 * (4 << r);
    addr_ack = 1'b1;
    wr(2'd0, {5'b11000, r});
    wait_irq("R12");
    wr(2'd2, 8'hA4); wr(2'd0, {5'b10000, r});
    while (!scl_line && n < 20000) begin @(negedge clk); n++; end
    while (scl_line && hi < 20000) begin @(negedge clk); hi++; end
    while (!scl_line && lo < 20000) begin @(negedge clk); lo++; end
    chk("R12", "SCL high time", hi, exp);
    chk("R12", "SCL low time", lo, exp);
    wait_irq("R12");
    expect_status("R12", 8'h18);
    wr(2'd0, {5'b10100, r});
    wait_stop("R11");
    rd(2'd0, v);
    chk("R13", "enable and rate kept", int'({v[7], v[2:0]}), int'({1'b1, r}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_regs();
    t_write_xfer();
    t_read_xfer();
    t_arbitration();
    t_bus_busy();
    t_rate(3'd2);
    t_rate(3'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule